// File: doc/BRIEF.md
# Bandwidth Regulator Pressure Generator

This block watches one initiator-to-target connection of an on-chip interconnect and tells the arbiter downstream whether the initiator is still inside its bandwidth allowance. It keeps a byte balance, often called a leaky bucket. Each accepted packet pours its byte length into the bucket. A programmed drain rate, which stands for the expected bandwidth, leaks out of it on every clock cycle. The drain rate is held in fixed point with four fractional bits, so the block can express rates below one byte per cycle with no error building up over time.

When a packet is accepted, the integer part of the balance is compared with a programmable watermark. If the balance is at or below the watermark, the initiator has used less than its allocation. The registered pressure bit then goes to 1 and the arbiter favours this initiator for low latency. If the balance is above the watermark, pressure goes to 0 and the initiator competes as best effort. Between packets the pressure bit keeps its value. Software programs the drain rate and the watermark through a simple write port.

Top module: `bw_pressure_gen`

## Requirements
- R1: After synchronous reset the balance is 0, the drain rate is 0, the watermark is 0 and pressure is 1.
- R2: A cycle with `pkt_acc` high adds `pkt_len` whole bytes to the balance.
- R3: Every cycle the balance drops by the drain rate, read as an unsigned number with 4 fractional bits (value r means r/16 bytes per cycle). Fractions build up exactly.
- R4: The balance never goes below zero. A drain larger than the balance leaves 0.
- R5: The balance saturates at its largest value, all integer and fraction bits set, and does not wrap.
- R6: On a cycle with `pkt_acc` high, pressure is loaded with 1 if the integer part of the balance before that packet is at or below the watermark, and with 0 otherwise. The new value appears after that clock edge.
- R7: In cycles without `pkt_acc`, pressure holds its value.
- R8: With `cfg_we` high, `cfg_sel`=0 writes the drain rate from the low bits of `cfg_wdata` and `cfg_sel`=1 writes the watermark. The drain that happens on the write edge still uses the old rate. The new value is used from the next cycle on.
- R9: A drain rate of 0 leaves the balance unchanged between packets.
- R10: A packet addition and the drain in the same cycle both take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_acc | input | 1 | A packet is accepted on the connection this cycle |
| pkt_len | input | LEN_W | Byte length of the accepted packet |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the drain rate, 1 selects the watermark |
| cfg_wdata | input | INT_W | Configuration write data |
| pressure | output | 1 | 1 = under allocation (priority), 0 = best effort |

## Verification
The hardest state to reach from the ports is a saturated balance. It takes more than 256 maximum-length packets with no drain. The bench gets there with the drain rate at 0 and a long run of 4095-byte packets. It then sets the watermark one below the integer ceiling, so a wrapped balance would give the opposite pressure. Fractional accumulation is tested in the same way: the bench sets a drain of 1/16 byte per cycle and places two probe packets on either side of the exact cycle where the integer part crosses the watermark. Zero-length packets serve as probes that sample the comparison without changing the balance.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    // Default geometry of the regulator
    localparam int DEF_LEN_W  = 12;  // packet byte length
    localparam int DEF_INT_W  = 20;  // integer bytes held in the balance
    localparam int DEF_FRAC_W = 4;   // fractional bits of balance and rate
    localparam int DEF_RATE_W = 12;  // drain rate register width (fixed point)

    // Configuration target selector
    typedef enum logic {
        CFG_RATE = 1'b0,
        CFG_MARK = 1'b1
    } cfg_sel_e;

    // Result of one balance update step
    typedef enum logic [1:0] {
        STEP_NORMAL = 2'd0,
        STEP_FLOOR  = 2'd1,
        STEP_CEIL   = 2'd2
    } step_kind_e;

endpackage

// File: rtl/bwp_cfg_regs.sv
module bwp_cfg_regs
    import bwp_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  cfg_sel_e          sel,
    input  logic [INT_W-1:0]  wdata,
    output logic [RATE_W-1:0] rate_q,
    output logic [INT_W-1:0]  mark_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            mark_q <= '0;
        end else if (we) begin
            case (sel)
                CFG_RATE: rate_q <= wdata[RATE_W-1:0];
                CFG_MARK: mark_q <= wdata;
                default:  ;
            endcase
        end
    end

    assert_mark_write_R8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == CFG_MARK) |=> (mark_q == $past(wdata)));

    assert_rate_write_R8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == CFG_RATE) |=> (rate_q == $past(wdata[RATE_W-1:0])));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(rate_q) && $stable(mark_q)));

endmodule

// File: rtl/bwp_balance.sv
module bwp_balance
    import bwp_pkg::*;
#(
    parameter int LEN_W  = DEF_LEN_W,
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    add_en,
    input  logic [LEN_W-1:0]        add_len,
    input  logic [RATE_W-1:0]       rate,
    output logic [INT_W+FRAC_W-1:0] bal_q,
    output step_kind_e              kind
);

    localparam int BAL_W = INT_W + FRAC_W;
    localparam int SUM_W = BAL_W + 1;
    localparam logic [BAL_W-1:0] BAL_MAX = {BAL_W{1'b1}};

    logic [SUM_W-1:0] add_fx;
    logic [SUM_W-1:0] sum_up;
    logic [SUM_W-1:0] rate_fx;
    logic [SUM_W-1:0] diff;
    logic [BAL_W-1:0] bal_d;

    // packet length converted to fixed point
    always_comb begin
        add_fx = '0;
        if (add_en) begin
            add_fx = SUM_W'(add_len) << FRAC_W;
        end
        rate_fx = SUM_W'(rate);
        sum_up  = {1'b0, bal_q} + add_fx;
        diff    = sum_up - rate_fx;
    end

    // clamp the combined add-and-drain result
    always_comb begin
        if (sum_up < rate_fx) begin
            kind  = STEP_FLOOR;
            bal_d = '0;
        end else if (diff > SUM_W'(BAL_MAX)) begin
            kind  = STEP_CEIL;
            bal_d = BAL_MAX;
        end else begin
            kind  = STEP_NORMAL;
            bal_d = diff[BAL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bal_q <= '0;
        end else begin
            bal_q <= bal_d;
        end
    end

    assert_drain_R3: assert property (@(posedge clk) disable iff (rst)
        (!add_en && (SUM_W'(bal_q) >= SUM_W'(rate)))
        |=> (SUM_W'(bal_q) == SUM_W'($past(bal_q)) - SUM_W'($past(rate))));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (!add_en && (SUM_W'(bal_q) < SUM_W'(rate))) |=> (bal_q == '0));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (bal_q == BAL_MAX && add_en && ((SUM_W'(add_len) << FRAC_W) >= SUM_W'(rate)))
        |=> (bal_q == BAL_MAX));

    assert_rate_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!add_en && rate == '0) |=> $stable(bal_q));

    assert_add_R2: assert property (@(posedge clk) disable iff (rst)
        (add_en && rate == '0 && bal_q == '0) |=> (bal_q == (BAL_W'($past(add_len)) << FRAC_W)));

endmodule

// File: rtl/bwp_pressure.sv
module bwp_pressure
    import bwp_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample,
    input  logic [INT_W+FRAC_W-1:0] bal,
    input  logic [INT_W-1:0]        mark,
    output logic                    press_q
);

    logic [INT_W-1:0] bal_int;
    logic             under;

    always_comb begin
        bal_int = bal[INT_W+FRAC_W-1:FRAC_W];
        under   = (bal_int <= mark);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            press_q <= 1'b1;
        end else if (sample) begin
            press_q <= under;
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(press_q));

endmodule

// File: rtl/bw_pressure_gen.sv
module bw_pressure_gen
    import bwp_pkg::*;
#(
    parameter int LEN_W  = DEF_LEN_W,
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_acc,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [INT_W-1:0] cfg_wdata,
    output logic             pressure
);

    localparam int BAL_W = INT_W + FRAC_W;

    logic [RATE_W-1:0] rate_q;
    logic [INT_W-1:0]  mark_q;
    logic [BAL_W-1:0]  bal_q;
    step_kind_e        step_kind;
    cfg_sel_e          sel_e;

    assign sel_e = cfg_sel_e'(cfg_sel);

    bwp_cfg_regs #(
        .INT_W (INT_W),
        .RATE_W(RATE_W)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (sel_e),
        .wdata (cfg_wdata),
        .rate_q(rate_q),
        .mark_q(mark_q)
    );

    bwp_balance #(
        .LEN_W (LEN_W),
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .RATE_W(RATE_W)
    ) u_bal (
        .clk    (clk),
        .rst    (rst),
        .add_en (pkt_acc),
        .add_len(pkt_len),
        .rate   (rate_q),
        .bal_q  (bal_q),
        .kind   (step_kind)
    );

    bwp_pressure #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W)
    ) u_prs (
        .clk    (clk),
        .rst    (rst),
        .sample (pkt_acc),
        .bal    (bal_q),
        .mark   (mark_q),
        .press_q(pressure)
    );

    // pressure after an accept reflects the pre-packet balance against the watermark
    assert_sample_R6: assert property (@(posedge clk) disable iff (rst)
        pkt_acc |=> (pressure == ($past(bal_q[BAL_W-1:FRAC_W]) <= $past(mark_q))));

    // accept together with drain: when nothing clamps, both terms apply
    assert_combined_R10: assert property (@(posedge clk) disable iff (rst)
        (pkt_acc && step_kind == STEP_NORMAL)
        |=> ((BAL_W+1)'(bal_q) == (BAL_W+1)'($past(bal_q))
             + ((BAL_W+1)'($past(pkt_len)) << FRAC_W) - (BAL_W+1)'($past(rate_q))));

endmodule

// File: tb/bw_pressure_gen_tb.sv
module bw_pressure_gen_tb_top;

    localparam int LEN_W = 12;
    localparam int INT_W = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pkt_acc = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [INT_W-1:0] cfg_wdata = '0;
    logic             pressure;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bw_pressure_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .pkt_acc  (pkt_acc),
        .pkt_len  (pkt_len),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .pressure (pressure)
    );

    typedef struct packed {
        logic             acc;
        logic [LEN_W-1:0] len;
        logic             we;
        logic             sel;
        logic [INT_W-1:0] wd;
        logic             exp;
    } vec_t;

    // sel 0 = drain rate (1/16 byte per cycle units), sel 1 = watermark
    localparam vec_t VECS [13] = '{
        '{1'b0, 12'd0,  1'b1, 1'b1, 20'd40, 1'b1},  // watermark 40
        '{1'b0, 12'd0,  1'b1, 1'b0, 20'd32, 1'b1},  // rate 2 B/cycle
        '{1'b1, 12'd30, 1'b0, 1'b0, 20'd0,  1'b1},  // bal 28
        '{1'b1, 12'd30, 1'b0, 1'b0, 20'd0,  1'b1},  // bal 56
        '{1'b1, 12'd0,  1'b0, 1'b0, 20'd0,  1'b0},  // 56 > 40
        '{1'b0, 12'd0,  1'b0, 1'b0, 20'd0,  1'b0},  // hold
        '{1'b0, 12'd0,  1'b0, 1'b0, 20'd0,  1'b0},  // hold
        '{1'b1, 12'd0,  1'b0, 1'b0, 20'd0,  1'b0},  // 50 > 40
        '{1'b0, 12'd0,  1'b1, 1'b1, 20'd48, 1'b0},  // watermark 48
        '{1'b1, 12'd0,  1'b0, 1'b0, 20'd0,  1'b1},  // 46 <= 48
        '{1'b0, 12'd0,  1'b1, 1'b0, 20'd8,  1'b1},  // rate 0.5 B/cycle
        '{1'b1, 12'd10, 1'b0, 1'b0, 20'd0,  1'b1},  // 42 <= 48, bal 51.5
        '{1'b1, 12'd0,  1'b0, 1'b0, 20'd0,  1'b0}   // 51 > 48
    };

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (pressure !== exp) begin
            n_fail++;
            $display("FAIL %s: pressure=%b expected=%b", req, pressure, exp);
        end
    endtask

    // drive one cycle; returns at the negedge after the edge that used it
    task automatic drive(input logic acc, input logic [LEN_W-1:0] len,
                         input logic we, input logic sel, input logic [INT_W-1:0] wd);
        pkt_acc = acc; pkt_len = len; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        @(negedge clk);
        pkt_acc = 1'b0; pkt_len = '0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic probe();
        drive(1'b1, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // table walk: R2 R6 R7 R8 R10 R3
        for (int k = 0; k < 13; k++) begin
            drive(VECS[k].acc, VECS[k].len, VECS[k].we, VECS[k].sel, VECS[k].wd);
            check(VECS[k].exp, $sformatf("R6/R7 vector %0d", k));
        end

        // R1: reset state
        do_reset();
        check(1'b1, "R1 reset pressure");
        probe();
        check(1'b1, "R1 zero balance vs zero watermark");

        // R4: large drain clamps at zero
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b0, 20'd4095);
        drive(1'b1, 12'd100, 1'b0, 1'b0, '0);
        probe();
        check(1'b1, "R4 floor at zero");

        // R5: saturation with no drain
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b1, 20'hFFFFE);
        for (int i = 0; i < 260; i++) drive(1'b1, 12'd4095, 1'b0, 1'b0, '0);
        probe();
        check(1'b0, "R5 saturated balance above watermark");
        drive(1'b0, '0, 1'b1, 1'b0, 20'd16);
        probe();
        check(1'b0, "R5 balance held at maximum");
        probe();
        check(1'b1, "R5 drain from maximum");

        // R9: zero rate keeps balance
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b1, 20'd5);
        drive(1'b1, 12'd6, 1'b0, 1'b0, '0);
        idle(50);
        probe();
        check(1'b0, "R9 no drain at rate zero");

        // R10: add and drain on the same edge
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b0, 20'd16);
        drive(1'b0, '0, 1'b1, 1'b1, 20'd9);
        drive(1'b1, 12'd10, 1'b0, 1'b0, '0);
        probe();
        check(1'b1, "R10 combined add and drain");

        // R3: fractional drain 1/16 byte per cycle
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b0, 20'd1);
        drive(1'b0, '0, 1'b1, 1'b1, 20'd8);
        drive(1'b1, 12'd10, 1'b0, 1'b0, '0);
        idle(15);
        probe();
        check(1'b0, "R3 fraction not yet crossed");
        probe();
        check(1'b1, "R3 fraction crossed");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule